// File: doc/BRIEF.md
# Word-Serial SHA-256 Padding Inserter

This block sits between a 32-bit message source and a SHA-256 message schedule. It applies the message padding one word at a time, on the fly. On each cycle it forms a byte-lane mask from the request qualifier, the end flag and the valid-byte code. Masked-off lanes are cleared to zero. The first masked-off lane receives the 0x80 marker byte, but only while the marker is still armed. The marker is armed once per message.

The block also keeps a running 64-bit message length in bits. Each accepted word adds eight bits for every valid lane. An external sequencer decides which word of a block is being formed, and drives a 2-bit selector. That selector makes the block emit the upper or lower half of the length in place of data at word positions 14 and 15. If the marker does not fit before word 14, the sequencer runs an extra block of padding only, and that block carries the length. A sticky error flag reports a partial byte code seen on a word that was not the last one.

Top module: `sha_pad_inserter`

## Requirements
- R1: After reset, or one cycle after `start_i` is high, the bit count is zero, the marker is armed and `err_o` is low. `start_i` takes priority over every other input in that cycle.
- R2: With `req_i`=1 and `last_i`=0, the lane mask is full: all four bytes of `din_i` appear unchanged on `dout_o` when `len_sel_i` is 00.
- R3: With `req_i`=1 and `last_i`=1, `byte_code_i` sets the number of valid bytes: 01 gives 1, 10 gives 2, 11 gives 3 and 00 gives 4. Message byte k sits at bits [31-8k -: 8], so byte 0 is bits 31:24. Lanes past the valid bytes that do not hold the marker are zero.
- R4: While the marker is armed, byte 0x80 is placed in the first lane after the valid bytes (lane index = number of valid bytes). No marker is placed when all four lanes are valid.
- R5: The marker disarms on the first word accepted with fewer than four valid lanes. Once disarmed, it stays disarmed until `start_i`.
- R6: With `req_i`=0 no lane is valid. The word is padding only: 0x80000000 if the marker is armed, otherwise zero.
- R7: `len_sel_i`=01 outputs bits 63:32 of the bit count and 10 outputs bits 31:0. Codes 00 and 11 output the padded data word.
- R8: On each cycle with `word_en_i`=1, the bit count increases by 8 times the number of valid lanes (0, 8, 16, 24 or 32). The new count is visible one cycle later.
- R9: A word accepted with `req_i`=1, `last_i`=0 and a nonzero `byte_code_i` sets `err_o` on the next cycle. `err_o` stays high until `start_i`.
- R10: With `word_en_i`=0 and `start_i`=0, the count, the marker state and the error flag do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new message: clears the count and the error, arms the marker |
| word_en_i | input | 1 | The current output word is consumed by the schedule |
| req_i | input | 1 | Data is being requested; when low, the word is padding |
| last_i | input | 1 | The current data word is the last of the message |
| byte_code_i | input | 2 | Valid-byte code for the last word |
| din_i | input | 32 | Message data word, first byte in bits 31:24 |
| len_sel_i | input | 2 | Length insert select: 01 upper half, 10 lower half |
| dout_o | output | 32 | Padded word or length half |
| err_o | output | 1 | Sticky byte-code error |

## Verification
`dout_o` is combinational from the inputs and the registered state. The bench therefore checks it in the same cycle that it drives the inputs, one nanosecond after the falling edge and well before the next rising edge. The bit count, the marker state and `err_o` change only at the rising edge. Their effects are checked in the following cycle: the count is read back through the length selector, the marker state through a padding-only word, and `err_o` directly. The bench sweeps every byte code, end-flag value, request value and several data patterns. Each run starts from `start_i` behind three full words, so the expected lengths come out of simple arithmetic.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LEN_W  = 64;

    typedef enum logic [1:0] {
        LSEL_DATA = 2'b00,
        LSEL_HI   = 2'b01,
        LSEL_LO   = 2'b10,
        LSEL_ALT  = 2'b11
    } len_sel_e;
endpackage

// File: rtl/sha_pad_lane_mask.sv
module sha_pad_lane_mask #(
    parameter int unsigned LANES  = 4,
    localparam int unsigned CODE_W = $clog2(LANES),
    localparam int unsigned CNT_W  = $clog2(LANES + 1)
) (
    input  logic              req_i,
    input  logic              last_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [LANES-1:0]  mask_o,
    output logic [CNT_W-1:0]  nvalid_o
);
    always_comb begin
        if (!req_i)
            nvalid_o = '0;
        else if (!last_i || code_i == '0)
            nvalid_o = CNT_W'(LANES);
        else
            nvalid_o = CNT_W'(code_i);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign mask_o[k] = (CNT_W'(k) < nvalid_o);
    end
endmodule

// File: rtl/sha_pad_byte_mux.sv
module sha_pad_byte_mux #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned LANES = WORD_W / BYTE_W
) (
    input  logic [WORD_W-1:0] din_i,
    input  logic [LANES-1:0]  mask_i,
    input  logic              armed_i,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [BYTE_W-1:0] MARKER = BYTE_W'(1) << (BYTE_W - 1);

    for (genvar k = 0; k < LANES; k++) begin : g_byte
        localparam int unsigned TOP = WORD_W - 1 - BYTE_W * k;
        logic marker_here;
        if (k == 0) begin : g_first
            assign marker_here = armed_i && !mask_i[0];
        end else begin : g_rest
            assign marker_here = armed_i && !mask_i[k] && mask_i[k-1];
        end
        assign word_o[TOP -: BYTE_W] = mask_i[k]    ? din_i[TOP -: BYTE_W] :
                                       marker_here ? MARKER : '0;
    end
endmodule

// File: rtl/sha_pad_inserter.sv
module sha_pad_inserter
    import sha_pad_pkg::*;
#(
    parameter int unsigned DATA_W = sha_pad_pkg::WORD_W,
    parameter int unsigned LANE_W = sha_pad_pkg::BYTE_W,
    parameter int unsigned CNT_W  = sha_pad_pkg::LEN_W,
    localparam int unsigned LANES  = DATA_W / LANE_W,
    localparam int unsigned CODE_W = $clog2(LANES),
    localparam int unsigned NV_W   = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              word_en_i,
    input  logic              req_i,
    input  logic              last_i,
    input  logic [CODE_W-1:0] byte_code_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic [1:0]        len_sel_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              err_o
);
    typedef struct packed {
        logic [CNT_W-1:0] bitcnt;
        logic             armed;
        logic             err;
    } pad_state_t;

    pad_state_t st_d, st_q;

    logic [LANES-1:0]  lane_mask;
    logic [NV_W-1:0]   nvalid;
    logic [DATA_W-1:0] padded;

    sha_pad_lane_mask #(.LANES(LANES)) u_mask (
        .req_i    (req_i),
        .last_i   (last_i),
        .code_i   (byte_code_i),
        .mask_o   (lane_mask),
        .nvalid_o (nvalid)
    );

    sha_pad_byte_mux #(.WORD_W(DATA_W), .BYTE_W(LANE_W)) u_bytes (
        .din_i   (din_i),
        .mask_i  (lane_mask),
        .armed_i (st_q.armed),
        .word_o  (padded)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.bitcnt = '0;
            st_d.armed  = 1'b1;
            st_d.err    = 1'b0;
        end else if (word_en_i) begin
            st_d.bitcnt = st_q.bitcnt + CNT_W'(nvalid) * CNT_W'(LANE_W);
            if (lane_mask != {LANES{1'b1}})
                st_d.armed = 1'b0;
            if (req_i && !last_i && byte_code_i != '0)
                st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bitcnt <= '0;
            st_q.armed  <= 1'b1;
            st_q.err    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (len_sel_i)
            LSEL_HI: dout_o = st_q.bitcnt[CNT_W-1 -: DATA_W];
            LSEL_LO: dout_o = st_q.bitcnt[DATA_W-1:0];
            default: dout_o = padded;
        endcase
    end

    assign err_o = st_q.err;

    AST_START_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.bitcnt == '0 && st_q.armed && !err_o)); // R1
    AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !last_i && len_sel_i == LSEL_DATA) |-> dout_o == din_i); // R2
    AST_IDLE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |-> lane_mask == '0); // R6
    AST_MARKER_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !start_i) |=> !st_q.armed); // R5
    AST_LEN_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (len_sel_i == LSEL_HI) |-> dout_o == st_q.bitcnt[CNT_W-1 -: DATA_W]); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_en_i && !start_i) |=> (st_q.bitcnt - $past(st_q.bitcnt)) <= CNT_W'(DATA_W)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_en_i && !start_i) |=> $stable(st_q)); // R10
endmodule

// File: tb/sha_pad_inserter_tb.sv
module sha_pad_inserter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, word_en_i = 1'b0, req_i = 1'b0, last_i = 1'b0;
    logic [1:0]  byte_code_i = '0, len_sel_i = '0;
    logic [31:0] din_i = '0;
    logic [31:0] dout_o;
    logic        err_o;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m_cnt;
    logic        m_armed, m_err;

    always #4 clk = ~clk;

    sha_pad_inserter dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_en_i(word_en_i),
        .req_i(req_i), .last_i(last_i), .byte_code_i(byte_code_i),
        .din_i(din_i), .len_sel_i(len_sel_i), .dout_o(dout_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int valid_bytes(input logic rq, input logic ls, input logic [1:0] cd);
        if (!rq) return 0;
        if (!ls || cd == 2'b00) return 4;
        return int'(cd);
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] d, input int n, input logic armed);
        logic [31:0] keep;
        logic [31:0] r;
        keep = (n == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - 8 * n));
        r = d & keep;
        if (armed && n < 4) r = r | (32'h80 << (24 - 8 * n));
        return r;
    endfunction

    // One cycle: drive at falling edge, check dout in the same cycle, update model.
    task automatic step(input logic st, input logic en, input logic rq, input logic ls,
                        input logic [1:0] cd, input logic [31:0] d, input logic [1:0] sel,
                        input string tag);
        int n;
        logic [31:0] e;
        @(negedge clk);
        start_i = st; word_en_i = en; req_i = rq; last_i = ls;
        byte_code_i = cd; din_i = d; len_sel_i = sel;
        #1;
        chk({tag, " R9 err"}, {31'b0, err_o}, {31'b0, m_err});
        n = valid_bytes(rq, ls, cd);
        if (sel == 2'b01) e = m_cnt[63:32];
        else if (sel == 2'b10) e = m_cnt[31:0];
        else e = exp_word(d, n, m_armed);
        chk(tag, dout_o, e);
        if (st) begin
            m_cnt = 64'h0; m_armed = 1'b1; m_err = 1'b0;
        end else if (en) begin
            m_cnt = m_cnt + 64'(8 * n);
            if (n != 4) m_armed = 1'b0;
            if (rq && !ls && cd != 2'b00) m_err = 1'b1;
        end
    endtask

    initial begin
        m_cnt = 64'h0; m_armed = 1'b1; m_err = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state: idle padding word shows armed marker, length zero
        step(0, 0, 0, 0, 2'b00, 32'hDEAD_BEEF, 2'b00, "R1 R6 reset marker");
        step(0, 0, 0, 0, 2'b00, 32'h0, 2'b10, "R1 reset len lo");
        step(0, 0, 0, 0, 2'b00, 32'h0, 2'b01, "R1 reset len hi");
        for (int cd = 0; cd < 4; cd++)
            for (int ls = 0; ls < 2; ls++)
                for (int rq = 0; rq < 2; rq++)
                    for (int p = 0; p < 4; p++) begin
                        logic [31:0] pat;
                        pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0123_4567 :
                              (p == 2) ? 32'hA5C3_3C5A : 32'h8080_8080;
                        step(1, 1, 1, 0, 2'b00, pat, 2'b00, "R1 start");
                        for (int w = 0; w < 3; w++)
                            step(0, 1, 1, 0, 2'b00, pat ^ 32'(w), 2'b00, "R2 full word");
                        step(0, 0, 1, 1, 2'(cd), pat, 2'b11, "R10 idle R7 alt sel");
                        step(0, 1, 1'(rq), 1'(ls), 2'(cd), pat, 2'b00, "R3 R4 R6 test word");
                        step(0, 0, 0, 0, 2'b00, 32'h0, 2'b10, "R8 len lo");
                        step(0, 0, 0, 0, 2'b00, 32'h0, 2'b01, "R7 len hi");
                        step(0, 1, 0, 0, 2'b00, pat, 2'b00, "R5 pad after");
                        step(0, 1, 0, 0, 2'b00, pat, 2'b00, "R5 pad again");
                        step(0, 0, 0, 0, 2'b00, 32'h0, 2'b10, "R8 len after pad");
                    end
        // R9 sticky error survives idle and full words, cleared by start
        step(1, 1, 1, 0, 2'b00, 32'h1111_1111, 2'b00, "R1 start err");
        step(0, 1, 1, 0, 2'b10, 32'h2222_2222, 2'b00, "R9 bad code");
        step(0, 0, 0, 0, 2'b00, 32'h0, 2'b00, "R9 idle");
        step(0, 1, 1, 0, 2'b00, 32'h3333_3333, 2'b00, "R9 good word");
        step(1, 0, 0, 0, 2'b00, 32'h0, 2'b00, "R9 start clears");
        step(0, 0, 0, 0, 2'b00, 32'h0, 2'b00, "R1 after start");
        // R10: last word with no accept does not disarm marker
        step(0, 0, 1, 1, 2'b01, 32'h4444_4444, 2'b00, "R10 no accept");
        step(0, 0, 0, 0, 2'b00, 32'h0, 2'b00, "R10 still armed");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule